// File: doc/BRIEF.md
# Unified Multi-Mode CORDIC Engine

This block evaluates shift-and-add vector iterations in circular, linear or hyperbolic coordinates on one shared datapath. A caller presents a start vector (x0, y0) and an angle word z0, chooses the coordinate system and whether the engine should drive the angle residual to zero (rotate) or the y component to zero (vector), and pulses `start`. The engine then runs a fixed number of iterations and pulses `done` with the final x, y and z words. Typical uses are sine and cosine, arctangent and magnitude, multiply and divide, and hyperbolic sine and cosine.

All words are 16-bit two's complement with 13 fraction bits, so a code c stands for c/8192 and the range is about ±4. One x and y adder-subtractor pair and one z adder-subtractor are reused on every clock. The per-step right shifts come from a logarithmic barrel shifter, and the elementary angle comes from a small table indexed by the step number. The processing gain is not corrected inside the block, and the input range is not reduced.

The controller has three states. IDLE waits for `start` (the transition START_ACCEPT moves to ITER and loads the operands). ITER performs one iteration per clock (transition STEP stays in ITER, and transition LAST_STEP moves to FIN after the final iteration). FIN raises `done` for one cycle (transition RETIRE returns to IDLE).

Top module: `cordic_unified`

## Requirements
- R1: While `rst_n` is low and after it is released, `done` is 0 and `xn`, `yn` and `zn` are 0 until the first accepted start.
- R2: A start accepted in circular or linear coordinates gives `done` high for exactly one cycle, beginning 14 clock edges (ITERS) after the edge that accepted start. Step indices run 0 to ITERS-1.
- R3: In hyperbolic coordinates, step indices start at 1, and index 4 and index 13 (each repeat point k being followed by 3k+1) are executed twice. With ITERS=14 this gives 15 steps, and `done` begins 15 edges after the accepting edge.
- R4: Circular rotation (`coord`=2'b00, `vec_mode`=0) selects +1 when z is at or above zero and −1 otherwise. It returns x = G(x0·cos z0 − y0·sin z0), y = G(y0·cos z0 + x0·sin z0) and z ≈ 0, where G is the product of sqrt(1+2^−2i) over the steps.
- R5: Circular vectoring (`vec_mode`=1) selects +1 when y is negative and −1 otherwise. It returns x = G·sqrt(x0²+y0²), y ≈ 0 and z = z0 + atan(y0/x0) for x0 > 0.
- R6: Linear rotation (`coord`=2'b01) keeps x equal to x0 on every step and returns y = y0 + x0·z0.
- R7: Linear vectoring returns x = x0 and z = z0 + y0/x0.
- R8: Hyperbolic (`coord`=2'b10) rotation returns x = G(x0·cosh z0 + y0·sinh z0) and y = G(y0·cosh z0 + x0·sinh z0). Vectoring returns x = G·sqrt(x0²−y0²) and z = z0 + atanh(y0/x0), where G is the product of sqrt(1−2^−2i) over the executed steps.
- R9: A `start` seen while the engine is in ITER or FIN is ignored. The running job finishes with its own result, and no second `done` follows.
- R10: After `done`, `xn`, `yn` and `zn` keep their values until the next accepted start.
- R11: Each step computes x' = x − m·d·(y>>>i), y' = y + d·(x>>>i) and z' = z − d·e_i, with arithmetic shifts and 16-bit wrap. m is +1, 0 or −1 for circular, linear or hyperbolic. e_i is round(8192·atan(2^−i)), 8192·2^−i or round(8192·atanh(2^−i)). The outputs match this recurrence bit for bit.
- R12: `coord`=2'b11 is treated as circular.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| coord | input | 2 | Coordinate system: 00 circular, 01 linear, 10 hyperbolic, 11 circular |
| vec_mode | input | 1 | 0 rotate toward zero angle, 1 vector toward zero y |
| x0 | input | 16 | Initial x, signed, 13 fraction bits |
| y0 | input | 16 | Initial y, signed, 13 fraction bits |
| z0 | input | 16 | Initial angle or accumulator, signed, 13 fraction bits |
| done | output | 1 | One-cycle completion pulse |
| xn | output | 16 | Final x |
| yn | output | 16 | Final y |
| zn | output | 16 | Final z |

## Verification
The assertions check on every cycle that `done` is a single-cycle pulse and that it arrives exactly when the step count matches the selected coordinate system. They also check that hyperbolic jobs never use index 0, that x is frozen during linear jobs, that a start seen during a job neither aborts it nor changes its coordinate system, and that the outputs hold while idle. The numerical results can be shown only by the bench's scenarios: bit-exact agreement with a behavioural model of the recurrence, and closeness to real-valued trigonometric, linear and hyperbolic references across signs and coordinate systems.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    typedef enum logic [1:0] {
        SYS_CIRC = 2'b00,
        SYS_LIN  = 2'b01,
        SYS_HYP  = 2'b10
    } coord_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ITER = 2'b01,
        ST_FIN  = 2'b10
    } phase_e;

    // fraction bits at which the elementary angle tables are written
    localparam int TBL_FRAC = 13;

endpackage

// File: rtl/cordic_ashr.sv
// Logarithmic arithmetic right shifter: one mux rank per shift-amount bit.
module cordic_ashr #(
    parameter int WIDTH = 16,
    parameter int SW    = 4
) (
    input  logic signed [WIDTH-1:0] din,
    input  logic        [SW-1:0]    sh,
    output logic signed [WIDTH-1:0] dout
);
    logic signed [WIDTH-1:0] stg [SW+1];

    assign stg[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_rank
        assign stg[k+1] = sh[k] ? (stg[k] >>> (2**k)) : stg[k];
    end

    assign dout = stg[SW];
endmodule

// File: rtl/cordic_angle_rom.sv
// Elementary angle per step index, for the selected coordinate system.
module cordic_angle_rom
    import cordic_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int IDXW  = 4
) (
    input  coord_e                  sys,
    input  logic        [IDXW-1:0]  idx,
    output logic signed [WIDTH-1:0] angle
);
    localparam int FRAC = WIDTH - 3;

    // round(2^13 * atan(2^-i)), i = 0..15
    localparam int CIRC_T [16] = '{6434, 3798, 2007, 1019, 511, 256, 128, 64,
                                   32, 16, 8, 4, 2, 1, 0, 0};
    // round(2^13 * atanh(2^-i)), i = 1..15 (entry 0 unused)
    localparam int HYP_T  [16] = '{0, 4500, 2092, 1029, 513, 256, 128, 64,
                                   32, 16, 8, 4, 2, 1, 0, 0};

    int raw;

    always_comb begin
        unique case (sys)
            SYS_LIN: raw = (1 << TBL_FRAC) >>> idx;
            SYS_HYP: raw = HYP_T[idx];
            default: raw = CIRC_T[idx];
        endcase
        if (FRAC >= TBL_FRAC) begin
            angle = WIDTH'(raw <<< (FRAC - TBL_FRAC));
        end else begin
            angle = WIDTH'(raw >>> (TBL_FRAC - FRAC));
        end
    end
endmodule

// File: rtl/cordic_iter.sv
// One unified iteration: shifted cross terms, direction decision, three add/subs.
module cordic_iter
    import cordic_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int IDXW  = 4
) (
    input  logic signed [WIDTH-1:0] x,
    input  logic signed [WIDTH-1:0] y,
    input  logic signed [WIDTH-1:0] z,
    input  logic signed [WIDTH-1:0] angle,
    input  logic        [IDXW-1:0]  idx,
    input  coord_e                  sys,
    input  logic                    vec,
    output logic signed [WIDTH-1:0] xo,
    output logic signed [WIDTH-1:0] yo,
    output logic signed [WIDTH-1:0] zo
);
    logic signed [WIDTH-1:0] x_sh, y_sh;
    logic                    d_pos;   // 1 selects d = +1

    cordic_ashr #(.WIDTH(WIDTH), .SW(IDXW)) u_shx (.din(x), .sh(idx), .dout(x_sh));
    cordic_ashr #(.WIDTH(WIDTH), .SW(IDXW)) u_shy (.din(y), .sh(idx), .dout(y_sh));

    // vectoring chases y to zero, rotation chases z to zero
    assign d_pos = vec ? y[WIDTH-1] : ~z[WIDTH-1];

    always_comb begin
        yo = d_pos ? (y + x_sh) : (y - x_sh);
        zo = d_pos ? (z - angle) : (z + angle);
        unique case (sys)
            SYS_LIN: xo = x;
            SYS_HYP: xo = d_pos ? (x + y_sh) : (x - y_sh);
            default: xo = d_pos ? (x - y_sh) : (x + y_sh);
        endcase
    end
endmodule

// File: rtl/cordic_seq.sv
// Step controller: IDLE -> ITER -> FIN, index stepping with hyperbolic repeats.
module cordic_seq
    import cordic_pkg::*;
#(
    parameter int ITERS = 14,
    parameter int IDXW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      coord,
    output logic            load,
    output logic            step,
    output logic            busy,
    output logic            done,
    output logic [IDXW-1:0] idx,
    output coord_e          sys
);
    localparam int              RPW       = IDXW + 3;
    localparam logic [IDXW-1:0] LAST_IDX  = IDXW'(ITERS - 1);
    localparam logic [RPW-1:0]  FIRST_REP = RPW'(4);

    phase_e          st_q, st_d;
    logic [IDXW-1:0] idx_q;
    logic [RPW-1:0]  rpt_q;      // next hyperbolic index to run twice
    logic            rdone_q;    // current index already run once more
    coord_e          sys_q, sys_in;
    logic            rep_now, last;

    always_comb begin
        unique case (coord)
            2'b01:   sys_in = SYS_LIN;
            2'b10:   sys_in = SYS_HYP;
            default: sys_in = SYS_CIRC;
        endcase
    end

    assign rep_now = (sys_q == SYS_HYP) && ({{(RPW-IDXW){1'b0}}, idx_q} == rpt_q) && !rdone_q;
    assign last    = (idx_q == LAST_IDX) && !rep_now;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_ITER;     // START_ACCEPT
            ST_ITER: if (last)  st_d = ST_FIN;      // LAST_STEP, else STEP
            ST_FIN:             st_d = ST_IDLE;     // RETIRE
            default:            st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // step bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            rpt_q   <= FIRST_REP;
            rdone_q <= 1'b0;
            sys_q   <= SYS_CIRC;
        end else if (st_q == ST_IDLE && start) begin
            sys_q   <= sys_in;
            idx_q   <= (sys_in == SYS_HYP) ? IDXW'(1) : '0;
            rpt_q   <= FIRST_REP;
            rdone_q <= 1'b0;
        end else if (st_q == ST_ITER && !last) begin
            if (rep_now) begin
                rdone_q <= 1'b1;
            end else begin
                idx_q   <= idx_q + IDXW'(1);
                rdone_q <= 1'b0;
                if (rdone_q) rpt_q <= rpt_q + {rpt_q[RPW-2:0], 1'b0} + RPW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        load = (st_q == ST_IDLE) && start;
        step = (st_q == ST_ITER);
        busy = (st_q == ST_ITER);
        done = (st_q == ST_FIN);
        idx  = idx_q;
        sys  = sys_q;
    end
endmodule

// File: rtl/cordic_unified.sv
module cordic_unified
    import cordic_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int ITERS = 14     // at most 16 (table depth)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              coord,
    input  logic                    vec_mode,
    input  logic signed [WIDTH-1:0] x0,
    input  logic signed [WIDTH-1:0] y0,
    input  logic signed [WIDTH-1:0] z0,
    output logic                    done,
    output logic signed [WIDTH-1:0] xn,
    output logic signed [WIDTH-1:0] yn,
    output logic signed [WIDTH-1:0] zn
);
    localparam int IDXW = (ITERS > 1) ? $clog2(ITERS) : 1;

    logic                    seq_load, seq_step, seq_busy, seq_done;
    logic [IDXW-1:0]         idx_w;
    coord_e                  sys_e;
    logic [1:0]              sys_w;
    logic                    vec_q;
    logic signed [WIDTH-1:0] x_q, y_q, z_q, x_nx, y_nx, z_nx, ang;

    assign sys_w = sys_e;

    cordic_seq #(.ITERS(ITERS), .IDXW(IDXW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .coord(coord),
        .load(seq_load), .step(seq_step), .busy(seq_busy), .done(seq_done),
        .idx(idx_w), .sys(sys_e)
    );

    cordic_angle_rom #(.WIDTH(WIDTH), .IDXW(IDXW)) u_rom (
        .sys(sys_e), .idx(idx_w), .angle(ang)
    );

    cordic_iter #(.WIDTH(WIDTH), .IDXW(IDXW)) u_iter (
        .x(x_q), .y(y_q), .z(z_q), .angle(ang), .idx(idx_w),
        .sys(sys_e), .vec(vec_q), .xo(x_nx), .yo(y_nx), .zo(z_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            z_q   <= '0;
            vec_q <= 1'b0;
        end else if (seq_load) begin
            x_q   <= x0;
            y_q   <= y0;
            z_q   <= z0;
            vec_q <= vec_mode;
        end else if (seq_step) begin
            x_q <= x_nx;
            y_q <= y_nx;
            z_q <= z_nx;
        end
    end

    assign done = seq_done;
    assign xn   = x_q;
    assign yn   = y_q;
    assign zn   = z_q;
endmodule

// File: rtl/cordic_unified_chk.sv
module cordic_unified_chk #(
    parameter int WIDTH = 16,
    parameter int ITERS = 14,
    parameter int IDXW  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    done,
    input logic signed [WIDTH-1:0] xn,
    input logic signed [WIDTH-1:0] yn,
    input logic signed [WIDTH-1:0] zn,
    input logic                    busy,
    input logic [1:0]              sys,
    input logic [IDXW-1:0]         idx,
    input logic signed [WIDTH-1:0] xw
);
    function automatic int hyp_steps();
        int n;
        int rp;
        n  = ITERS - 1;
        rp = 4;
        while (rp < ITERS) begin
            n++;
            rp = 3 * rp + 1;
        end
        return n;
    endfunction

    localparam int HYP_N = hyp_steps();

    int cnt;   // iterations since the accepting edge

    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= 0;
        else if (start && !busy && !done) cnt <= 0;
        else if (busy)                    cnt <= cnt + 1;
    end

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == ((sys == 2'b10) ? HYP_N : ITERS)));

    assert_hyp_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sys == 2'b10) |-> (idx != '0));

    assert_linear_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sys == 2'b01) |=> $stable(xw));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ((busy || done) && $stable(sys)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(xn) && $stable(yn) && $stable(zn)));
endmodule

bind cordic_unified cordic_unified_chk #(.WIDTH(WIDTH), .ITERS(ITERS), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .xn(xn), .yn(yn), .zn(zn),
    .busy(seq_busy), .sys(sys_w), .idx(idx_w), .xw(x_q)
);

// File: tb/cordic_unified_test.sv
`timescale 1ns/1ps
module cordic_unified_test;
    localparam int  N   = 14;
    localparam real SC  = 8192.0;
    localparam int  TOL = 24;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         coord = 2'b00;
    logic               vec_mode = 1'b0;
    logic signed [15:0] x0 = '0, y0 = '0, z0 = '0;
    logic               done;
    logic signed [15:0] xn, yn, zn;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    cordic_unified #(.WIDTH(16), .ITERS(N)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .coord(coord), .vec_mode(vec_mode),
        .x0(x0), .y0(y0), .z0(z0), .done(done), .xn(xn), .yn(yn), .zn(zn)
    );

    function automatic int toq(real r);
        return (r >= 0.0) ? $rtoi(r * SC + 0.5) : -$rtoi(-r * SC + 0.5);
    endfunction

    function automatic int wrap16(int v);
        logic signed [15:0] t;
        t = v[15:0];
        return int'(t);
    endfunction

    function automatic int elem(int s, int i);
        if (s == 1) return 8192 >>> i;
        if (s == 2) return $rtoi($atanh($pow(2.0, real'(-i))) * SC + 0.5);
        return $rtoi($atan($pow(2.0, real'(-i))) * SC + 0.5);
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_near(string req, string what, int act, real exp_r);
        int e;
        e = toq(exp_r);
        checks++;
        if (act > e + TOL || act < e - TOL) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (+/-%0d)", req, what, act, e, TOL);
        end
    endtask

    // one job: behavioural model, drive, then compare on every clock
    task automatic run_op(int sys_sel, bit vec, real rx0, real ry0, real rz0,
                          real ex, real ey, real ez, string req, int inj);
        int q[$];
        int sysm, rp, mx, my, mz, xs, ys, a, nx, steps;
        bit dpos;
        real gain;
        string dreq;
        sysm = (sys_sel == 3) ? 0 : sys_sel;
        rp   = 4;
        for (int i = (sysm == 2) ? 1 : 0; i < N; i++) begin
            q.push_back(i);
            if (sysm == 2 && i == rp) begin
                q.push_back(i);
                rp = 3 * rp + 1;
            end
        end
        mx = toq(rx0); my = toq(ry0); mz = toq(rz0);
        gain = 1.0;
        foreach (q[j]) begin
            xs   = mx >>> q[j];
            ys   = my >>> q[j];
            a    = elem(sysm, q[j]);
            dpos = vec ? (my < 0) : (mz >= 0);
            if (sysm == 1)      nx = mx;
            else if (sysm == 2) nx = dpos ? mx + ys : mx - ys;
            else                nx = dpos ? mx - ys : mx + ys;
            my = wrap16(dpos ? my + xs : my - xs);
            mz = wrap16(dpos ? mz - a : mz + a);
            mx = wrap16(nx);
            if (sysm == 0) gain = gain * $sqrt(1.0 + $pow(2.0, real'(-2 * q[j])));
            if (sysm == 2) gain = gain * $sqrt(1.0 - $pow(2.0, real'(-2 * q[j])));
        end
        steps = q.size();
        dreq  = (sysm == 2) ? "R3" : "R2";

        @(negedge clk);
        coord = 2'(sys_sel); vec_mode = vec;
        x0 = 16'(toq(rx0)); y0 = 16'(toq(ry0)); z0 = 16'(toq(rz0));
        start = 1'b1;
        @(negedge clk);
        for (int k = 0; k <= steps + 3; k++) begin
            start = (k == inj);
            if (k == inj) begin   // R9: disturb inputs while busy
                x0 = 16'sh1234; y0 = -16'sh0400; z0 = 16'sh0777; coord = 2'b01;
            end
            check_eq(dreq, $sformatf("done at step %0d", k), int'(done), (k == steps) ? 1 : 0);
            if (k == steps) begin
                check_eq("R11", "x exact", int'(xn), mx);
                check_eq("R11", "y exact", int'(yn), my);
                check_eq("R11", "z exact", int'(zn), mz);
                check_near(req, "x", int'(xn), gain * ex);
                check_near(req, "y", int'(yn), gain * ey);
                check_near(req, "z", int'(zn), ez);
            end
            if (k == steps + 3) begin
                check_eq("R10", "x held", int'(xn), mx);
                check_eq("R10", "y held", int'(yn), my);
                check_eq("R10", "z held", int'(zn), mz);
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "done after reset", int'(done), 0);
        check_eq("R1", "xn after reset", int'(xn), 0);
        check_eq("R1", "yn after reset", int'(yn), 0);
        check_eq("R1", "zn after reset", int'(zn), 0);

        // R4 circular rotation
        run_op(0, 0, 0.60725, 0.0, 0.6,
               0.60725 * $cos(0.6), 0.60725 * $sin(0.6), 0.0, "R4", -1);
        run_op(0, 0, 0.5, 0.3, -1.2,
               0.5 * $cos(-1.2) - 0.3 * $sin(-1.2), 0.3 * $cos(-1.2) + 0.5 * $sin(-1.2), 0.0, "R4", -1);
        // R5 circular vectoring
        run_op(0, 1, 0.6, 0.8, 0.0, 1.0, 0.0, $atan2(0.8, 0.6), "R5", -1);
        run_op(0, 1, 0.9, -0.4, 0.1, $sqrt(0.97), 0.0, 0.1 + $atan2(-0.4, 0.9), "R5", -1);
        // R6 linear rotation
        run_op(1, 0, 0.75, 0.5, 1.25, 0.75, 1.4375, 0.0, "R6", -1);
        run_op(1, 0, -0.5, 0.25, -1.5, -0.5, 1.0, 0.0, "R6", -1);
        // R7 linear vectoring
        run_op(1, 1, 1.5, 0.9, 0.25, 1.5, 0.0, 0.85, "R7", -1);
        // R8 hyperbolic rotation and vectoring
        run_op(2, 0, 1.0, 0.0, 0.5, $cosh(0.5), $sinh(0.5), 0.0, "R8", -1);
        run_op(2, 1, 1.2, 0.5, 0.0, $sqrt(1.19), 0.0, $atanh(0.5 / 1.2), "R8", -1);
        // R12 code 2'b11 behaves as circular
        run_op(3, 0, 0.60725, 0.0, -0.9,
               0.60725 * $cos(-0.9), 0.60725 * $sin(-0.9), 0.0, "R12", -1);
        // R9 start while busy is ignored (circular and hyperbolic)
        run_op(0, 0, 0.4, -0.2, 1.0,
               0.4 * $cos(1.0) + 0.2 * $sin(1.0), -0.2 * $cos(1.0) + 0.4 * $sin(1.0), 0.0, "R9", 5);
        run_op(2, 0, 1.0, 0.2, -0.4,
               $cosh(-0.4) + 0.2 * $sinh(-0.4), 0.2 * $cosh(-0.4) + $sinh(-0.4), 0.0, "R9", 14);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule